// File: doc/BRIEF.md
# Rate-Limited Host Interrupt Aggregator

This block merges a set of internal event sources into one interrupt line towards the host. The sources are FIFO level events, GPIO edges with a programmable trigger direction, a general-purpose timer expiry and power-management wake events. Every source has a sticky status bit that is set by its event. Software clears it by writing a one, and an enable bit decides whether it may raise the line. A master enable gates the line as a whole and leaves the status bits untouched.

The line is driven through a data/output-enable pair that stands for the pad. In push-pull mode the pad is always driven, and the active level is selected as high or low. In open-drain mode the pad is pulled low while the interrupt is active and released otherwise, so several devices can share one wire. Open-drain mode therefore always signals active-low. After the line drops, an 8-bit hold-off interval counted in slow ticks (about 10 us each) must elapse before it may rise again. This caps the interrupt rate the host sees.

Top module: `irq_aggregator`

## Requirements
- R1: The internal active state rises on the clock edge after a pending condition exists, when no hold-off count remains. Pending means the master enable is high and at least one status bit is set with its enable bit high. The active state falls on the clock edge after pending goes away.
- R2: A one-cycle event on a source sets its sticky status bit at the next clock edge. The bit stays set until it is cleared. Status bit positions: FIFO events occupy bits 0 to 3, GPIO 0 to 2 occupy bits 4 to 6, the timer occupies bit 7 and the wake event occupies bit 8.
- R3: With `clr_wr_i` high, each status bit whose `clr_mask_i` bit is one is cleared at the clock edge, and bits whose mask bit is zero are kept. An event arriving in the same cycle as its clear leaves the bit set.
- R4: A set status bit whose enable bit is zero does not make the line active.
- R5: With `master_en_i` low the line is inactive from the next clock edge onward, and the status bits keep their values.
- R6: Each GPIO source triggers on a rising edge when its `gpio_rise_i` bit is 1 and on a falling edge when it is 0. The opposite edge is ignored, and a level already present when reset is released produces no event.
- R7: In push-pull mode (`open_drain_i` = 0) `irq_oe_o` is 1. `irq_do_o` equals the active state when `pol_high_i` = 1 and its inverse when `pol_high_i` = 0.
- R8: In open-drain mode (`open_drain_i` = 1) `irq_do_o` is 0 and `irq_oe_o` equals the active state, whatever `pol_high_i` is.
- R9: When the active state falls, a hold-off count is loaded from `holdoff_i` and drops by one on each cycle with `tick_i` high. It does not change on other cycles. The active state cannot rise while the count is non-zero. The earliest rise is at the clock edge after the one that brings the count to zero, and a zero interval allows a rise at the next edge.
- R10: After reset all status bits are 0, the active state is 0 and the hold-off count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_evt_i | input | NFIFO | FIFO level event pulses |
| gpio_i | input | NGPIO | GPIO levels, already synchronised |
| gpio_rise_i | input | NGPIO | Per GPIO: 1 triggers on rising edge, 0 on falling |
| timer_evt_i | input | 1 | General-purpose timer expiry pulse |
| wake_evt_i | input | 1 | Power-management wake event pulse |
| en_mask_i | input | NSRC | Per-source enable bits |
| master_en_i | input | 1 | Global interrupt enable |
| clr_wr_i | input | 1 | Strobe for the write-one-to-clear of status |
| clr_mask_i | input | NSRC | Bits to clear when `clr_wr_i` is high |
| pol_high_i | input | 1 | Push-pull active level: 1 high, 0 low |
| open_drain_i | input | 1 | 1 selects open-drain output |
| holdoff_i | input | HOLD_W | Hold-off interval in ticks |
| tick_i | input | 1 | Slow tick pulse for the hold-off count |
| status_o | output | NSRC | Sticky status bits |
| irq_do_o | output | 1 | Pad data |
| irq_oe_o | output | 1 | Pad output enable |

## Verification
A status bit that is lost or set wrongly appears on `status_o` at the clock edge after the event or clear. A wrong pending decision reaches the pad one edge later. An error in the hold-off counter, such as a wrong load value, counting without a tick or an early release, moves the re-assertion edge. The bench therefore measures that edge to the cycle after a fixed number of ticks. Pad encoding faults are visible at once in both output modes and at both polarities, because the pad stage is purely combinational.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef struct packed {
    logic drive;
    logic enable;
  } pad_t;

  // Edge qualification for one GPIO source
  function automatic logic edge_hit(input logic prev, input logic cur, input logic rise);
    if (rise) return (~prev) & cur;
    return prev & (~cur);
  endfunction

  // Pad encoding from active state and output mode
  function automatic pad_t pad_encode(input logic active, input logic pol_high,
                                      input logic od);
    pad_t p;
    if (od) begin
      p.drive  = 1'b0;
      p.enable = active;
    end else begin
      p.drive  = pol_high ? active : ~active;
      p.enable = 1'b1;
    end
    return p;
  endfunction

endpackage

// File: rtl/irq_gpio_edge.sv
module irq_gpio_edge #(
  parameter int NGPIO = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGPIO-1:0] gpio_i,
  input  logic [NGPIO-1:0] rise_sel_i,
  output logic [NGPIO-1:0] hit_o
);
  import irq_agg_pkg::*;

  logic [NGPIO-1:0] prev_q;
  logic             primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= gpio_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NGPIO; g++) begin : g_bit
    assign hit_o[g] = primed_q & edge_hit(prev_q[g], gpio_i[g], rise_sel_i[g]);
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NSRC = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] clr_mask_i,
  input  logic [NSRC-1:0] en_mask_i,
  input  logic            master_en_i,
  output logic [NSRC-1:0] status_o,
  output logic            pending_o
);
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] clr_eff;

  assign clr_eff = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_eff) | set_i;
  end

  assign status_o  = status_q;
  assign pending_o = master_en_i & (|(status_q & en_mask_i));

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_eff)) == '0)); // R2
  AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((status_q & $past(clr_mask_i & ~set_i)) == '0)); // R3

endmodule

// File: rtl/irq_holdoff_gate.sv
module irq_holdoff_gate #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending_i,
  input  logic              tick_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  output logic              active_o
);
  logic              act_q;
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      if (!pending_i) begin
        act_q <= 1'b0;
        cnt_q <= holdoff_i;
      end
    end else if (cnt_q != '0) begin
      if (tick_i) cnt_q <= cnt_q - 1'b1;
    end else if (pending_i) begin
      act_q <= 1'b1;
    end
  end

  assign active_o = act_q;

  AST_RISE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(pending_i)); // R1
  AST_FALL_LOADS_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> (cnt_q == $past(holdoff_i))); // R9
  AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && cnt_q != '0) |=> !act_q); // R9
  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && cnt_q != '0 && !tick_i) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NFIFO  = 4,
  parameter int NGPIO  = 3,
  parameter int HOLD_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NFIFO-1:0]       fifo_evt_i,
  input  logic [NGPIO-1:0]       gpio_i,
  input  logic [NGPIO-1:0]       gpio_rise_i,
  input  logic                   timer_evt_i,
  input  logic                   wake_evt_i,
  input  logic [NFIFO+NGPIO+1:0] en_mask_i,
  input  logic                   master_en_i,
  input  logic                   clr_wr_i,
  input  logic [NFIFO+NGPIO+1:0] clr_mask_i,
  input  logic                   pol_high_i,
  input  logic                   open_drain_i,
  input  logic [HOLD_W-1:0]      holdoff_i,
  input  logic                   tick_i,
  output logic [NFIFO+NGPIO+1:0] status_o,
  output logic                   irq_do_o,
  output logic                   irq_oe_o
);
  import irq_agg_pkg::*;

  localparam int NSRC = NFIFO + NGPIO + 2;

  logic [NGPIO-1:0] gpio_hit;
  logic [NSRC-1:0]  src_set;
  logic             pending;
  logic             irq_active;
  pad_t             pad;

  irq_gpio_edge #(.NGPIO(NGPIO)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .gpio_i     (gpio_i),
    .rise_sel_i (gpio_rise_i),
    .hit_o      (gpio_hit)
  );

  assign src_set = {wake_evt_i, timer_evt_i, gpio_hit, fifo_evt_i};

  irq_status_bank #(.NSRC(NSRC)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (src_set),
    .clr_wr_i    (clr_wr_i),
    .clr_mask_i  (clr_mask_i),
    .en_mask_i   (en_mask_i),
    .master_en_i (master_en_i),
    .status_o    (status_o),
    .pending_o   (pending)
  );

  irq_holdoff_gate #(.HOLD_W(HOLD_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending),
    .tick_i    (tick_i),
    .holdoff_i (holdoff_i),
    .active_o  (irq_active)
  );

  assign pad      = pad_encode(irq_active, pol_high_i, open_drain_i);
  assign irq_do_o = pad.drive;
  assign irq_oe_o = pad.enable;

  AST_MASTER_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en_i |=> !irq_active); // R5
  AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !open_drain_i |-> irq_oe_o); // R7
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    open_drain_i |-> !irq_do_o); // R8
  AST_OD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (open_drain_i && !irq_active) |-> !irq_oe_o); // R8

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] fifo_evt;
  logic [2:0] gpio, gpio_rise;
  logic       timer_evt, wake_evt;
  logic [8:0] en_mask, clr_mask, status;
  logic       master_en, clr_wr, pol_high, open_drain, tick;
  logic [7:0] holdoff;
  logic       irq_do, irq_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_evt_i(fifo_evt), .gpio_i(gpio),
    .gpio_rise_i(gpio_rise), .timer_evt_i(timer_evt), .wake_evt_i(wake_evt),
    .en_mask_i(en_mask), .master_en_i(master_en), .clr_wr_i(clr_wr),
    .clr_mask_i(clr_mask), .pol_high_i(pol_high), .open_drain_i(open_drain),
    .holdoff_i(holdoff), .tick_i(tick), .status_o(status),
    .irq_do_o(irq_do), .irq_oe_o(irq_oe)
  );

  // Table: [17:14] source bit, [13:5] enable mask, [4] master, [3] pol_high,
  // [2] open_drain, [1] expected pad data, [0] expected pad enable
  localparam logic [17:0] TBL [9] = '{
    {4'd0, 9'h1FF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd1, 9'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd2, 9'h1FF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd3, 9'h1F7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd7, 9'h1FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd8, 9'h1FF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd7, 9'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd8, 9'h0FF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd3, 9'h1F7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic clear_all();
    clr_mask = 9'h1FF; clr_wr = 1'b1;
    step(1);
    clr_wr = 1'b0;
    step(2);
  endtask

  task automatic pulse_src(input int b);
    if (b < 4) fifo_evt[b] = 1'b1;
    else if (b == 7) timer_evt = 1'b1;
    else if (b == 8) wake_evt = 1'b1;
    step(1);
    fifo_evt = '0; timer_evt = 1'b0; wake_evt = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1); tick = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; fifo_evt = '0; gpio = 3'b001; gpio_rise = 3'b111;
    timer_evt = 0; wake_evt = 0; en_mask = 9'h1FF; master_en = 1;
    clr_wr = 0; clr_mask = '0; pol_high = 1; open_drain = 0; holdoff = 0; tick = 0;
    step(3);
    rst_n = 1'b1;
    step(3);
    chk("R10 reset status (R6 no event from reset level)", status, 9'h000);
    chk("R10 reset pad data", irq_do, 1'b0);
    chk("R10 reset pad enable", irq_oe, 1'b1);

    // Table walk: R1 R2 R4 R5 R7 R8
    for (int e = 0; e < 9; e++) begin
      en_mask = TBL[e][13:5]; master_en = TBL[e][4];
      pol_high = TBL[e][3]; open_drain = TBL[e][2];
      step(1);
      pulse_src(int'(TBL[e][17:14]));
      step(1);
      chk($sformatf("R1/R4/R5/R7/R8 entry %0d pad data", e), irq_do, TBL[e][1]);
      chk($sformatf("R1/R4/R5/R7/R8 entry %0d pad enable", e), irq_oe, TBL[e][0]);
      chk($sformatf("R2 entry %0d status bit", e), status[TBL[e][17:14]], 1'b1);
      clear_all();
    end

    en_mask = 9'h1FF; master_en = 1; pol_high = 1; open_drain = 0; holdoff = 0;
    step(1);

    // R3 partial clear and set-wins
    fifo_evt[0] = 1; timer_evt = 1; step(1); fifo_evt = '0; timer_evt = 0;
    chk("R2 two sources set", status, 9'h081);
    clr_mask = 9'h001; clr_wr = 1; step(1); clr_wr = 0;
    chk("R3 masked clear keeps others", status, 9'h080);
    fifo_evt[0] = 1; clr_mask = 9'h001; clr_wr = 1; step(1);
    fifo_evt = '0; clr_wr = 0;
    chk("R3 set wins over same-cycle clear", status, 9'h081);
    clear_all();

    // R5 master gate
    master_en = 0; pulse_src(8); step(2);
    chk("R5 master off keeps line inactive", irq_do, 1'b0);
    chk("R5 master off keeps status", status, 9'h100);
    master_en = 1; step(1);
    chk("R5 master on asserts", irq_do, 1'b1);
    master_en = 0; step(1);
    chk("R5 master off drops line", irq_do, 1'b0);
    chk("R5 status survives gating", status, 9'h100);
    clear_all();

    // R6 GPIO edges: bits 0,1 rising, bit 2 falling
    master_en = 0; gpio_rise = 3'b011;
    gpio = 3'b011; step(1);
    chk("R6 rising edge on gpio1 sets bit5", status, 9'h020);
    clear_all();
    gpio = 3'b001; step(1);
    chk("R6 falling edge ignored on rising gpio1", status, 9'h000);
    gpio = 3'b101; step(1);
    chk("R6 rising edge ignored on falling gpio2", status, 9'h000);
    gpio = 3'b001; step(1);
    chk("R6 falling edge on gpio2 sets bit6", status, 9'h040);
    clear_all();

    // R9 hold-off
    master_en = 1; holdoff = 8'd3; step(1);
    pulse_src(1); step(1);
    chk("R9 line active before hold-off", irq_do, 1'b1);
    clr_mask = 9'h1FF; clr_wr = 1; step(1); clr_wr = 0; step(1);
    chk("R9 line dropped", irq_do, 1'b0);
    pulse_src(2); step(1);
    chk("R9 blocked during hold-off", irq_do, 1'b0);
    step(4);
    chk("R9 no count without tick", irq_do, 1'b0);
    ticks(2);
    chk("R9 blocked after two ticks", irq_do, 1'b0);
    ticks(1);
    chk("R9 still low at edge reaching zero", irq_do, 1'b0);
    step(1);
    chk("R9 re-asserts one edge after zero", irq_do, 1'b1);
    holdoff = 8'd0;
    clr_mask = 9'h1FF; clr_wr = 1; step(1); clr_wr = 0; step(1);
    chk("R9 dropped with zero interval", irq_do, 1'b0);
    pulse_src(0); step(1);
    chk("R9 zero interval allows immediate rise", irq_do, 1'b1);
    clear_all();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule